// File: doc/BRIEF.md
# Path BIP-8 Generator with Error Injection

This block sits in the transmit path ahead of the scrambler. It watches a byte stream that carries several byte-interleaved STS-1 paths. For each path it computes an 8-bit even-parity code over the bytes it sends out. Each code bit is the XOR of the matching bit position of every byte that counts toward the code.

A frame-start strobe ends the current frame. On that strobe the block captures each channel's running code and restarts the accumulation. The captured code then goes into that channel's path-parity slot in the following frame. The three leading columns of every frame carry section and line overhead, and those bytes are left out of the code. The byte placed in the parity slot is part of the transmitted data, so it counts toward the next code.

For testing, a channel that has its error enable set inverts its next parity byte after each pulse on a shared error strobe. The output is one byte per accepted input byte. A parameter selects whether the output is registered or combinational.

Top module: `path_bip8_gen`

## Requirements
- R1: In registered mode, every byte accepted with `byte_en` high leaves on `dout` one cycle later with `dout_valid` high. A byte outside a parity slot leaves unchanged. `dout_valid` is low in the cycle after a cycle where `byte_en` is low.
- R2: A byte marked by `b3_slot[c]` on channel `c` is replaced by channel `c`'s code. The code is the bitwise XOR of every byte transmitted on channel `c` during the previous frame.
- R3: The code includes the transmitted parity-slot byte of the previous frame, and it includes any inversion applied to that byte.
- R4: Bytes presented with `oh_col` high (the three overhead columns) are excluded from the code.
- R5: An accepted byte with `frame_start` high latches all channel codes and restarts accumulation. In the first frame after reset, the parity slots carry 0x00.
- R6: Each channel keeps its own code and its own error state, and traffic on one channel never alters another channel's code.
- R7: A pulse on `err_strobe` while `err_en[c]` is high inverts the next parity-slot byte of channel `c`. It inverts that one byte only, and several pulses before the slot still cause a single inversion.
- R8: A channel whose `err_en` bit is low during a strobe pulse is not inverted by that pulse.
- R9: A strobe pulse in the same cycle as a channel's parity slot does not affect that slot. It arms the inversion for that channel's following slot.
- R10: During reset, `dout_valid` and `dout` are 0 and no inversion is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_en | input | 1 | A stream byte is present this cycle |
| chan | input | clog2(NCH) (2) | Channel that owns the present byte |
| din | input | W (8) | Stream byte before parity insertion |
| frame_start | input | 1 | Present byte is the first byte of a frame |
| oh_col | input | 1 | Present byte lies in an overhead column (excluded) |
| b3_slot | input | NCH (3) | One-hot parity-slot mark, bit = channel |
| err_en | input | NCH (3) | Per-channel error-injection enable |
| err_strobe | input | 1 | Shared error-injection pulse |
| dout_valid | output | 1 | `dout` carries a transmitted byte |
| dout | output | W (8) | Transmitted byte |

## Verification
The assertions assume three things about the inputs:
- At most one `b3_slot` bit is set, and only the bit that matches `chan`.
- `chan` is below NCH whenever `byte_en` is high.
- `frame_start` only comes with an accepted byte.

The stimulus meets these assumptions because a row, column and channel counter derives every framing input. The slot mark is fixed at row 1, column 3 of each channel. Only the data bytes, the idle gaps, the enables and the strobe timing are random.

// File: rtl/b3_pkg.sv
package b3_pkg;
   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;
endpackage

// File: rtl/b3_lane.sv
module b3_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         beat,
   input  logic         restart,
   input  logic         excl,
   input  logic [W-1:0] tx,
   output logic [W-1:0] hold
);
   logic [W-1:0] acc;
   logic         take;

   assign take = beat && !excl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc  <= '0;
         hold <= '0;
      end else if (restart) begin
         hold <= acc;
         acc  <= take ? tx : '0;
      end else if (take) begin
         acc <= acc ^ tx;
      end
   end

   // R5
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> $stable(hold));
   // R4
   excl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat && excl && !restart |=> $stable(acc));
endmodule

// File: rtl/b3_arm.sv
module b3_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic consume,
   output logic pend
);
   always_ff @(posedge clk) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= (pend && !consume) || arm;
   end

   // R7
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      consume && !arm |=> !pend);
   // R8
   no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm && !pend |=> !pend);
endmodule

// File: rtl/path_bip8_gen.sv
module path_bip8_gen
   import b3_pkg::*;
#(
   parameter int        NCH      = 3,
   parameter int        W        = 8,
   parameter out_mode_e OUT_MODE = OUT_REG,
   localparam int       CW       = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           byte_en,
   input  logic [CW-1:0]  chan,
   input  logic [W-1:0]   din,
   input  logic           frame_start,
   input  logic           oh_col,
   input  logic [NCH-1:0] b3_slot,
   input  logic [NCH-1:0] err_en,
   input  logic           err_strobe,
   output logic           dout_valid,
   output logic [W-1:0]   dout
);
   if (NCH < 1 || NCH > 64) begin : g_bad_nch
      $error("path_bip8_gen: NCH out of range");
   end
   if (W < 1) begin : g_bad_w
      $error("path_bip8_gen: W must be positive");
   end

   logic [W-1:0]   hold_a [NCH];
   logic [NCH-1:0] pend;
   logic           hit;
   logic           inj;
   logic           restart;
   logic [W-1:0]   tx;

   assign restart = byte_en && frame_start;

   always_comb begin
      hit = byte_en && b3_slot[chan];
      inj = hit && pend[chan];
      tx  = hit ? (hold_a[chan] ^ {W{inj}}) : din;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_lane
      logic beat;
      assign beat = byte_en && (chan == CW'(i));

      b3_lane #(.W(W)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .beat    (beat),
         .restart (restart),
         .excl    (oh_col),
         .tx      (tx),
         .hold    (hold_a[i])
      );

      b3_arm u_arm (
         .clk     (clk),
         .rst_n   (rst_n),
         .arm     (err_strobe && err_en[i]),
         .consume (beat && hit),
         .pend    (pend[i])
      );
   end

   if (OUT_MODE == OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dout_valid <= 1'b0;
            dout       <= '0;
         end else begin
            dout_valid <= byte_en;
            if (byte_en) dout <= tx;
         end
      end

      // R1
      pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
         byte_en && !hit |=> dout_valid && dout == $past(din));
      // R1
      idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !byte_en |=> !dout_valid);
   end else begin : g_comb
      assign dout_valid = byte_en;
      assign dout       = tx;
   end

   // R2
   slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(b3_slot));
   // R6
   slot_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_en && (b3_slot != '0) |-> b3_slot[chan]);
   // R6
   chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_en |-> int'(chan) < NCH);
   // R5
   fs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> byte_en);
   // R10
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> pend == '0);
endmodule

// File: tb/tb_path_bip8_gen.sv
module tb_path_bip8_gen;
   localparam int NCH = 3;
   localparam int W   = 8;
   localparam int NFR = 10;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           byte_en;
   logic [1:0]     chan;
   logic [W-1:0]   din;
   logic           frame_start;
   logic           oh_col;
   logic [NCH-1:0] b3_slot;
   logic [NCH-1:0] err_en;
   logic           err_strobe;
   logic           dout_valid;
   logic [W-1:0]   dout;

   always #2 clk = ~clk;

   path_bip8_gen dut (
      .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .chan(chan), .din(din),
      .frame_start(frame_start), .oh_col(oh_col), .b3_slot(b3_slot),
      .err_en(err_en), .err_strobe(err_strobe),
      .dout_valid(dout_valid), .dout(dout)
   );

   int unsigned vectors = 0;
   int unsigned fails   = 0;
   bit          done    = 0;

   logic [W-1:0] m_acc  [NCH];
   logic [W-1:0] m_hold [NCH];
   logic         m_pend [NCH];
   string        frame_tag [NFR];

   function automatic logic [W-1:0] model_beat(input logic [W-1:0] d, input int ch,
                                                input int r, input int c, input bit stb,
                                                output bit injected);
      bit hit;
      logic [W-1:0] tx;
      hit = (r == 1 && c == 3);
      injected = hit && m_pend[ch];
      tx = hit ? (m_hold[ch] ^ {W{injected}}) : d;
      if (r == 0 && c == 0 && ch == 0) begin
         for (int i = 0; i < NCH; i++) begin
            m_hold[i] = m_acc[i];
            m_acc[i]  = '0;
         end
      end
      if (c >= 3) m_acc[ch] = m_acc[ch] ^ tx;
      for (int i = 0; i < NCH; i++) begin
         bit cons;
         cons = hit && (ch == i);
         m_pend[i] = (m_pend[i] && !cons) || (stb && err_en[i]);
      end
      return tx;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp,
                        input int ch, input int r, input int c);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s ch%0d row%0d col%0d: actual=%h expected=%h", tag, ch, r, c, act, exp);
      end
   endtask

   task automatic idle();
      byte_en = 1'b0; din = W'($urandom); frame_start = 1'b0; oh_col = 1'b0;
      b3_slot = '0; err_strobe = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R1", {7'd0, dout_valid}, 8'd0, 0, 0, 0);
   endtask

   task automatic send(input logic [W-1:0] d, input int ch, input int r, input int c,
                       input bit stb, input string ftag);
      logic [W-1:0] exp;
      bit inj;
      string tag;
      byte_en = 1'b1; chan = 2'(ch); din = d;
      frame_start = (r == 0 && c == 0 && ch == 0);
      oh_col = (c < 3);
      b3_slot = (r == 1 && c == 3) ? NCH'(1 << ch) : '0;
      err_strobe = stb;
      exp = model_beat(d, ch, r, c, stb, inj);
      if (r == 1 && c == 3) tag = (inj && ftag == "R6") ? "R7" : ftag;
      else tag = "R1";
      @(posedge clk);
      @(negedge clk);
      check("R1", {7'd0, dout_valid}, 8'd1, ch, r, c);
      check(tag, dout, exp, ch, r, c);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < NCH; i++) begin
         m_acc[i] = '0; m_hold[i] = '0; m_pend[i] = 1'b0;
      end
      frame_tag[0] = "R5"; frame_tag[1] = "R2"; frame_tag[2] = "R2";
      frame_tag[3] = "R4"; frame_tag[4] = "R7"; frame_tag[5] = "R9";
      for (int f = 6; f < NFR; f++) frame_tag[f] = "R6";
      frame_tag[4] = "R3";

      rst_n = 1'b0; byte_en = 1'b0; chan = '0; din = '0; frame_start = 1'b0;
      oh_col = 1'b0; b3_slot = '0; err_en = '0; err_strobe = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      check("R10", {7'd0, dout_valid}, 8'd0, 0, 0, 0);
      check("R10", dout, 8'd0, 0, 0, 0);
      rst_n = 1'b1;

      for (int f = 0; f < NFR; f++) begin
         if (f < 3)       err_en = 3'b000;
         else if (f == 3) err_en = 3'b101;  // R8: ch1 disabled
         else if (f == 4) err_en = 3'b111;
         else             err_en = NCH'($urandom);
         for (int r = 0; r < 9; r++) begin
            for (int c = 0; c < 90; c++) begin
               for (int ch = 0; ch < NCH; ch++) begin
                  logic [W-1:0] d;
                  bit stb;
                  string tg;
                  d = W'($urandom);
                  // R4: frame 2 has a zero payload, random overhead
                  if (f == 2 && c >= 3) d = '0;
                  stb = 1'b0;
                  if (f == 3 && r == 0 && c == 10 && ch == 0) stb = 1'b1;
                  if (f == 4 && r == 0 && (c == 10 || c == 20) && ch == 0) stb = 1'b1;
                  // R9: strobe in ch1's slot cycle
                  if (f == 4 && r == 1 && c == 3 && ch == 1) stb = 1'b1;
                  if (f >= 5 && ($urandom % 400) == 0) stb = 1'b1;
                  tg = frame_tag[f];
                  if (f == 3) tg = (ch == 1) ? "R8" : "R7";
                  if (($urandom % 8) == 0) idle();
                  send(d, ch, r, c, stb, tg);
               end
            end
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule